// File: doc/BRIEF.md
# Two-Tone Keyed Frame Transmitter with CRC-8

This block holds a short frame of bytes and turns it into a repeating keyed tone sequence. It is meant to steer an external two-register frequency synthesizer. A host fills the frame store through a write port. When transmission is enabled, the block first computes a CRC-8 over the frame body and places the checksum in the final byte slot. It then walks the frame one bit at a time. For each bit it asks a synthesizer control sequencer, through a request/acknowledge pair, to select frequency register 0 or 1. Once the selection is acknowledged, it opens a tone window followed by a silent guard window.

After the last bit of the last byte, a longer silent gap follows. The block then returns to its idle point. If enable is still high there, it recomputes the checksum and starts the frame again from byte 0. Every duration is given in milliseconds and converted to clock ticks through a ticks-per-millisecond parameter.

Top module: `fsk_burst_framer`

## Requirements
- R1: While reset is asserted, and on the first cycle after its release, `sel_req` and `tone_en` are low.
- R2: At each frame start the block computes a CRC-8 over slots 1 to FRAME_BYTES-2. Slot 0 is the header and is left out. The polynomial is 0x07, the start value 0x00, bits are taken most significant first, and there is no reflection and no final XOR. The CRC step takes one clock per byte, so FRAME_BYTES-2 cycles, and the first select request is raised right after it. The result overwrites slot FRAME_BYTES-1. For body FF D0 59 E4 CC 1A 2A the transmitted last byte is 0x89.
- R3: Bytes are sent from slot 0 upward, and within a byte from bit 0 to bit 7. `sel_bit` equals the bit being sent: 0 selects frequency register 0 and 1 selects frequency register 1.
- R4: `sel_req` stays high with `sel_bit` steady until `sel_ack` is sampled high. An acknowledge that arrives while no request is pending has no effect.
- R5: `tone_en` rises on the cycle after the acknowledge. It stays high for exactly ON_MS*TICKS_PER_MS cycles and is then low for exactly GUARD_MS*TICKS_PER_MS cycles before the next request. `tone_en` and `sel_req` are never high together.
- R6: After the guard window of the last bit, a further GAP_MS*TICKS_PER_MS cycles pass with both outputs low. The block then spends one idle cycle before any new frame begins.
- R7: `enable` is sampled only at the idle point between frames. Dropping it during a frame lets the frame and its gap finish, after which the block stays idle.
- R8: Host writes land in the store on the next clock and are used by the next frame. A value the host writes into the CRC slot is replaced by the computed checksum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request, sampled between frames |
| wr_en | input | 1 | Frame store write strobe |
| wr_addr | input | $clog2(FRAME_BYTES) | Frame store byte address |
| wr_data | input | 8 | Frame store write byte |
| sel_ack | input | 1 | Sequencer acknowledge of a register select |
| sel_req | output | 1 | Register select request |
| sel_bit | output | 1 | Frequency register to select (0 or 1) |
| tone_en | output | 1 | Tone gate to the synthesizer output path |

## Verification
Two pairs of events can fall on the same clock. The first is an acknowledge arriving on the very cycle a request first appears. The bench's acknowledge delay cycles through 0 to 3, so zero-latency handshakes occur throughout every frame. A stray acknowledge is also injected in the middle of each tone window to show it neither shortens the window nor starts a new bit. The second is an enable change against the frame boundary. Enable is dropped in the middle of the second frame, and the bench's cycle model, which samples enable only at idle, must agree with the design on every clock through the rest of that frame, its gap and the idle stretch that follows.

// File: rtl/fsk_framer_pkg.sv
package fsk_framer_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CRC,
    PH_SEL,
    PH_TONE,
    PH_GUARD,
    PH_GAP
  } phase_t;

  // One byte through an MSB-first, non-reflected CRC-8.
  function automatic logic [7:0] crc8_byte(input logic [7:0] acc,
                                           input logic [7:0] data,
                                           input logic [7:0] poly);
    logic [7:0] c;
    c = acc ^ data;
    for (int k = 0; k < 8; k++) begin
      c = c[7] ? ((c << 1) ^ poly) : (c << 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/frame_store.sv
module frame_store #(
  parameter int N  = 9,
  parameter int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          crc_we,
  input  logic [7:0]    crc_val,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  logic [7:0] mem [N];

  for (genvar i = 0; i < N; i++) begin : g_slot
    logic       host_hit;
    logic       slot_we;
    logic [7:0] slot_d;

    assign host_hit = wr_en && (wr_addr == AW'(i));

    if (i == N - 1) begin : g_crc_slot
      // The checksum write takes priority over a host write to this slot.
      assign slot_we = crc_we || host_hit;
      assign slot_d  = crc_we ? crc_val : wr_data;
    end else begin : g_body_slot
      assign slot_we = host_hit;
      assign slot_d  = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[i] <= 8'h00;
      end else if (slot_we) begin
        mem[i] <= slot_d;
      end
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/crc8_accum.sv
module crc8_accum
  import fsk_framer_pkg::*;
#(
  parameter logic [7:0] POLY = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic [7:0] din,
  output logic [7:0] crc_next
);

  logic [7:0] acc_q;
  logic [7:0] acc_d;

  assign crc_next = crc8_byte(acc_q, din, POLY);

  always_comb begin
    acc_d = acc_q;
    if (clr)     acc_d = 8'h00;
    else if (en) acc_d = crc_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= 8'h00;
    else        acc_q <= acc_d;
  end

endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic          done
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign done = run && (cnt_q == limit - CW'(1));

  always_comb begin
    if (!run || done) cnt_d = '0;
    else              cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < limit));

endmodule

// File: rtl/fsk_burst_framer.sv
module fsk_burst_framer
  import fsk_framer_pkg::*;
#(
  parameter int         FRAME_BYTES  = 9,
  parameter int         TICKS_PER_MS = 200000,
  parameter int         ON_MS        = 8,
  parameter int         GUARD_MS     = 8,
  parameter int         GAP_MS       = 16,
  parameter logic [7:0] CRC_POLY     = 8'h07,
  localparam int        AW           = $clog2(FRAME_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          sel_ack,
  output logic          sel_req,
  output logic          sel_bit,
  output logic          tone_en
);

  localparam int ON_TICKS    = ON_MS * TICKS_PER_MS;
  localparam int GUARD_TICKS = GUARD_MS * TICKS_PER_MS;
  localparam int GAP_TICKS   = GAP_MS * TICKS_PER_MS;
  localparam int MAX_A       = (ON_TICKS > GUARD_TICKS) ? ON_TICKS : GUARD_TICKS;
  localparam int MAX_TICKS   = (MAX_A > GAP_TICKS) ? MAX_A : GAP_TICKS;
  localparam int CW          = $clog2(MAX_TICKS + 1);
  localparam logic [AW-1:0] LAST_BODY = AW'(FRAME_BYTES - 2);
  localparam logic [AW-1:0] LAST_SLOT = AW'(FRAME_BYTES - 1);

  phase_t        phase_q, phase_d;
  logic [AW-1:0] byte_q, byte_d;
  logic [2:0]    bit_q, bit_d;

  logic          crc_clr, crc_en, crc_we;
  logic [7:0]    crc_next;
  logic [7:0]    rd_data;
  logic          t_run, t_done;
  logic [CW-1:0] t_limit;

  frame_store #(.N(FRAME_BYTES), .AW(AW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .crc_we  (crc_we),
    .crc_val (crc_next),
    .rd_addr (byte_q),
    .rd_data (rd_data)
  );

  crc8_accum #(.POLY(CRC_POLY)) u_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (crc_clr),
    .en       (crc_en),
    .din      (rd_data),
    .crc_next (crc_next)
  );

  interval_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (t_run),
    .limit (t_limit),
    .done  (t_done)
  );

  assign t_run = (phase_q == PH_TONE) || (phase_q == PH_GUARD) || (phase_q == PH_GAP);

  always_comb begin
    case (phase_q)
      PH_TONE:  t_limit = CW'(ON_TICKS);
      PH_GUARD: t_limit = CW'(GUARD_TICKS);
      default:  t_limit = CW'(GAP_TICKS);
    endcase
  end

  assign sel_req = (phase_q == PH_SEL);
  assign sel_bit = rd_data[bit_q];
  assign tone_en = (phase_q == PH_TONE);

  // Next-state process
  always_comb begin
    phase_d = phase_q;
    byte_d  = byte_q;
    bit_d   = bit_q;
    crc_clr = 1'b0;
    crc_en  = 1'b0;
    crc_we  = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        crc_clr = 1'b1;
        if (enable) begin
          phase_d = PH_CRC;
          byte_d  = AW'(1);
        end
      end
      PH_CRC: begin
        crc_en = 1'b1;
        if (byte_q == LAST_BODY) begin
          crc_we  = 1'b1;
          phase_d = PH_SEL;
          byte_d  = '0;
          bit_d   = '0;
        end else begin
          byte_d = byte_q + AW'(1);
        end
      end
      PH_SEL: begin
        if (sel_ack) phase_d = PH_TONE;
      end
      PH_TONE: begin
        if (t_done) phase_d = PH_GUARD;
      end
      PH_GUARD: begin
        if (t_done) begin
          if (bit_q == 3'd7 && byte_q == LAST_SLOT) begin
            phase_d = PH_GAP;
            byte_d  = '0;
            bit_d   = '0;
          end else begin
            phase_d = PH_SEL;
            bit_d   = bit_q + 3'd1;
            if (bit_q == 3'd7) byte_d = byte_q + AW'(1);
          end
        end
      end
      PH_GAP: begin
        if (t_done) phase_d = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      byte_q  <= '0;
      bit_q   <= '0;
    end else begin
      phase_q <= phase_d;
      byte_q  <= byte_d;
      bit_q   <= bit_d;
    end
  end

  assert_tone_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(tone_en && sel_req));

  assert_sel_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_req && !sel_ack) |=> (sel_req && $stable(sel_bit)));

  assert_tone_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_req && sel_ack) |=> $rose(tone_en));

  assert_crc_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_CRC) |-> (byte_q >= AW'(1) && byte_q <= LAST_BODY));

  assert_gap_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_GAP) |=> !tone_en);

endmodule

// File: tb/tb_fsk_burst_framer.sv
`timescale 1ns/1ps
module tb_fsk_burst_framer;

  localparam int N     = 9;
  localparam int TPM   = 2;
  localparam int AW    = $clog2(N);
  localparam int ON_T  = 8 * TPM;
  localparam int GRD_T = 8 * TPM;
  localparam int GAP_T = 16 * TPM;

  logic clk = 1'b0;
  logic rst_n, enable, wr_en, sel_ack;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data;
  logic sel_req, sel_bit, tone_en;

  always #2.5 clk = ~clk;

  fsk_burst_framer #(.FRAME_BYTES(N), .TICKS_PER_MS(TPM)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .sel_ack(sel_ack),
    .sel_req(sel_req), .sel_bit(sel_bit), .tone_en(tone_en)
  );

  int tests = 0, fails = 0;
  int cycles = 0;
  bit timed_out = 0;

  // Behavioural reference state
  byte unsigned mem [N];
  int mph = 0;       // 0 idle,1 crc,2 select,3 tone,4 guard,5 gap
  int mcnt = 0, mbyte = 0, mbit = 0;
  int frames = 0, ack_wait = 0, ack_delay = 0;
  logic [7:0] cap = 8'h00;

  function automatic logic [7:0] ref_crc();
    logic [7:0] c = 8'h00;
    logic fb;
    for (int b = 1; b <= N - 2; b++) begin
      for (int k = 7; k >= 0; k--) begin
        fb = c[7] ^ mem[b][k];
        c = {c[6:0], 1'b0};
        if (fb) c = c ^ 8'h07;
      end
    end
    return c;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called at a negedge with inputs already set for the coming posedge.
  task automatic cycle();
    string tag;
    int exp_req, exp_tone;
    logic [7:0] want;
    cycles++;
    if (cycles > 100000 && !timed_out) begin
      timed_out = 1;
      check("watchdog", cycles, 100000);
    end
    exp_req  = (rst_n && mph == 2) ? 1 : 0;
    exp_tone = (rst_n && mph == 3) ? 1 : 0;
    if (!rst_n)        tag = "R1";
    else if (mph == 0) tag = "R7";
    else if (mph == 5) tag = "R6";
    else if (mph == 1) tag = "R2";
    else               tag = "R5";
    check({tag, " sel_req"}, int'(sel_req), exp_req);
    check({tag, " tone_en"}, int'(tone_en), exp_tone);
    if (exp_req == 1) check("R3 sel_bit", int'(sel_bit), int'(mem[mbyte][mbit]));

    // acknowledge driver: varying latency, plus a stray pulse inside each tone (R4)
    sel_ack = 1'b0;
    if (rst_n && mph == 2) begin
      if (ack_wait >= ack_delay) sel_ack = 1'b1;
      else ack_wait++;
    end else if (rst_n && mph == 3 && mcnt == 3) begin
      sel_ack = 1'b1;
    end

    if (rst_n) begin
      case (mph)
        0: if (enable) begin mph = 1; mcnt = 0; end
        1: if (mcnt == N - 3) begin
             mem[N-1] = ref_crc(); mph = 2; mbyte = 0; mbit = 0;
           end else mcnt++;
        2: if (sel_ack) begin
             cap[mbit] = sel_bit; mph = 3; mcnt = 0;
             ack_wait = 0; ack_delay = (ack_delay + 1) % 4;
           end
        3: if (mcnt == ON_T - 1) begin mph = 4; mcnt = 0; end else mcnt++;
        4: if (mcnt == GRD_T - 1) begin
             mcnt = 0;
             if (mbit == 7 && mbyte == N - 1) begin
               frames++;
               want = (frames == 1) ? 8'h89 : ref_crc();
               check((frames == 3) ? "R8 crc byte" : "R2 crc byte", int'(cap), int'(want));
               mph = 5; mbyte = 0; mbit = 0;
             end else begin
               if (mbit == 7) begin mbit = 0; mbyte++; end else mbit++;
               mph = 2;
             end
           end else mcnt++;
        5: if (mcnt == GAP_T - 1) begin mph = 0; mcnt = 0; end else mcnt++;
        default: mph = 0;
      endcase
      if (wr_en) mem[wr_addr] = wr_data;
    end
    @(negedge clk);
  endtask

  task automatic write_byte(input int a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    cycle();
    wr_en = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; enable = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = 8'h00; sel_ack = 1'b0;
    for (int i = 0; i < N; i++) mem[i] = 8'h00;
    @(negedge clk);
    for (int i = 0; i < 4; i++) cycle();      // R1 reset state
    rst_n = 1'b1;
    cycle();                                  // R1 first cycle after release
    write_byte(0, 8'hAA); write_byte(1, 8'hFF); write_byte(2, 8'hD0);
    write_byte(3, 8'h59); write_byte(4, 8'hE4); write_byte(5, 8'hCC);
    write_byte(6, 8'h1A); write_byte(7, 8'h2A);
    write_byte(8, 8'h55);                     // R8: host value in CRC slot is replaced
    enable = 1'b1;
    while (frames < 1 && !timed_out) cycle();
    // second frame: drop enable mid-frame (R7)
    while (!(frames == 1 && mph == 2 && mbyte == 4) && !timed_out) cycle();
    enable = 1'b0;
    while (frames < 2 && !timed_out) cycle();
    for (int i = 0; i < 150 && !timed_out; i++) cycle();
    check("R7 idle after drop", mph, 0);
    // new payload while idle (R8)
    write_byte(0, 8'h3C); write_byte(1, 8'h01); write_byte(2, 8'h80);
    write_byte(5, 8'h00); write_byte(7, 8'hF7);
    enable = 1'b1;
    while (frames < 3 && !timed_out) cycle();
    for (int i = 0; i < 10 && !timed_out; i++) cycle();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule